// File: doc/BRIEF.md
# Next-PC and Control-Transfer Unit for a 32-bit Integer Core

This block decides where a 32-bit integer core fetches next. It takes one instruction word, the address of that instruction and the two source register values. From these it produces the next fetch address, a flag that says whether the flow is redirected, and a link value with a write enable for the destination register. It covers the direct jump, the register-indirect jump and the six conditional branches. Every other instruction moves on to the sequential address. The unit has no registers. A core can place it in the execute stage and feed its outputs to the fetch mux and to the writeback port.

The branch and direct-jump offsets sit in scrambled bit positions in the instruction word, so the unit rebuilds them before it adds them to the PC. The register-indirect jump adds a 12-bit signed offset to the first source register and then clears bit 0 of the sum. Targets need only 2-byte alignment. The unit raises no misalignment fault.

Top module: `rvbr_nextpc_unit`

## Requirements
- R1: When opcode bits [6:0] are none of 1100011 (branch), 1101111 (direct jump) or 1100111 (indirect jump), the unit outputs next PC = PC+4, redirect = 0, link write enable = 0 and illegal = 0.
- R2: A direct jump (opcode 1101111) redirects to PC + sext(off). The 21-bit offset is {instr[31], instr[19:12], instr[20], instr[30:21], 0}, which covers -1 MiB up to +1 MiB-2.
- R3: An indirect jump (opcode 1100111) redirects to (rs1 + sext(instr[31:20])) with bit 0 forced to 0.
- R4: Both jump kinds output a link value of PC+4. The link write enable is high only for a jump whose rd field instr[11:7] is non-zero. Branches and all other instructions keep it low.
- R5: A branch with funct3 instr[14:12] = 000 is taken when rs1 == rs2. With funct3 = 001 it is taken when rs1 != rs2.
- R6: A branch with funct3 = 100 is taken when rs1 < rs2 as two's-complement values. With funct3 = 101 it is taken when rs1 >= rs2 as two's-complement values.
- R7: A branch with funct3 = 110 is taken when rs1 < rs2 as unsigned values. With funct3 = 111 it is taken when rs1 >= rs2 as unsigned values.
- R8: A taken branch redirects to PC + sext(off). The 13-bit offset is {instr[31], instr[7], instr[30:25], instr[11:8], 0}. A branch that is not taken outputs PC+4 with redirect = 0.
- R9: A branch with funct3 = 010 or 011 raises the illegal flag and is never taken (next PC = PC+4).
- R10: All address sums wrap modulo 2^32. For example, PC = FFFFFFFC gives a sequential address of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word being executed |
| pc_i | input | XLEN | Address of that instruction |
| src1_i | input | XLEN | Value of the first source register |
| src2_i | input | XLEN | Value of the second source register |
| next_pc_o | output | XLEN | Next fetch address |
| redirect_o | output | 1 | High when control leaves the sequential path |
| link_val_o | output | XLEN | Return address to write to rd |
| link_we_o | output | 1 | Write enable for the link value |
| br_illegal_o | output | 1 | Branch with a reserved condition code |

## Verification
The hardest cases to reach are the extreme offsets, because every bit of the rebuilt immediate matters there. The most negative and most positive direct-jump and branch offsets only come out right if the bit that sits lowest in the instruction word lands high in the offset. The bench encodes each offset into an instruction itself, following the field layout in R2 and R8, and sweeps both ends of each range together with pseudo-random values. The comparison corners are also hard to hit: equal operands, values on either side of the sign boundary, and all-ones against zero. The bench crosses these operands with all eight condition codes so that the signed and unsigned orders disagree.

// File: rtl/rvbr_pkg.sv
// Package: shared opcodes, condition codes and the transfer-kind type
// for the next-PC unit. Assumes the 32-bit base encoding with
// instr[1:0] = 11.
package rvbr_pkg;

    localparam int unsigned ILEN = 32;

    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;

    typedef enum logic [1:0] {
        XFER_NONE,
        XFER_BRANCH,
        XFER_JAL,
        XFER_JALR
    } xfer_kind_e;

    localparam logic [2:0] CMP_EQ  = 3'b000;
    localparam logic [2:0] CMP_NE  = 3'b001;
    localparam logic [2:0] CMP_LT  = 3'b100;
    localparam logic [2:0] CMP_GE  = 3'b101;
    localparam logic [2:0] CMP_LTU = 3'b110;
    localparam logic [2:0] CMP_GEU = 3'b111;

    // Maps an opcode to the kind of control transfer it requests.
    function automatic xfer_kind_e classify(input logic [6:0] opc);
        unique case (opc)
            OPC_BRANCH: return XFER_BRANCH;
            OPC_JAL:    return XFER_JAL;
            OPC_JALR:   return XFER_JALR;
            default:    return XFER_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rvbr_imm_unpack.sv
// Module: rebuilds the sign-extended branch, direct-jump and 12-bit
// immediates from instruction bits [31:7]. The sign always comes from
// instruction bit 31. Assumes XLEN >= 21.
module rvbr_imm_unpack #(
    parameter int unsigned XLEN = 32
) (
    input  logic [31:7]     ibits_i,
    output logic [XLEN-1:0] imm_b_o,
    output logic [XLEN-1:0] imm_j_o,
    output logic [XLEN-1:0] imm_i_o
);
    localparam int unsigned BW = 13;
    localparam int unsigned JW = 21;
    localparam int unsigned IW = 12;

    logic [BW-1:0] raw_b;
    logic [JW-1:0] raw_j;
    logic [IW-1:0] raw_i;
    logic          sgn;

    // Gathers the scattered offset fields into contiguous offsets.
    always_comb begin
        sgn   = ibits_i[31];
        raw_b = {ibits_i[31], ibits_i[7], ibits_i[30:25], ibits_i[11:8], 1'b0};
        raw_j = {ibits_i[31], ibits_i[19:12], ibits_i[20], ibits_i[30:21], 1'b0};
        raw_i = ibits_i[31:20];
    end

    // Sign-extends each offset to the register width.
    always_comb begin
        imm_b_o = {{(XLEN-BW){sgn}}, raw_b};
        imm_j_o = {{(XLEN-JW){sgn}}, raw_j};
        imm_i_o = {{(XLEN-IW){sgn}}, raw_i};
    end

    // Offsets that are always even, sign taken from bit 31 (R2, R8).
    always_comb begin
        p_even_offsets_r8: assert (imm_b_o[0] == 1'b0 && imm_j_o[0] == 1'b0)
            else $error("odd branch or jump offset");
        p_sign_source_r2: assert (imm_j_o[XLEN-1] == imm_b_o[XLEN-1])
            else $error("sign bits of offsets disagree");
    end

endmodule

// File: rtl/rvbr_cond_eval.sv
// Module: evaluates a branch condition on two operands. Reserved codes
// 010 and 011 are reported as bad and never taken.
module rvbr_cond_eval #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] lhs_i,
    input  logic [XLEN-1:0] rhs_i,
    input  logic [2:0]      code_i,
    output logic            take_o,
    output logic            bad_code_o
);
    import rvbr_pkg::*;

    logic eq;
    logic lt_s;
    logic lt_u;

    // Computes the three primitive relations between the operands.
    always_comb begin
        eq   = (lhs_i == rhs_i);
        lt_s = ($signed(lhs_i) < $signed(rhs_i));
        lt_u = (lhs_i < rhs_i);
    end

    // Selects the relation that the condition code asks for.
    always_comb begin
        bad_code_o = 1'b0;
        case (code_i)
            CMP_EQ:  take_o = eq;
            CMP_NE:  take_o = !eq;
            CMP_LT:  take_o = lt_s;
            CMP_GE:  take_o = !lt_s;
            CMP_LTU: take_o = lt_u;
            CMP_GEU: take_o = !lt_u;
            default: begin
                take_o     = 1'b0;
                bad_code_o = 1'b1;
            end
        endcase
    end

    // Equal operands cannot be ordered either way (R5, R6, R7).
    always_comb begin
        p_eq_excludes_less_r5: assert (!(eq && (lt_s || lt_u)))
            else $error("equal operands reported as ordered");
        p_sign_split_r6: assert (!(lhs_i[XLEN-1] != rhs_i[XLEN-1]) || (lt_s != lt_u))
            else $error("signed and unsigned order agree across sign boundary");
    end

endmodule

// File: rtl/rvbr_target_sel.sv
// Module: forms the sequential address and the two redirect targets,
// and picks the next PC from the transfer kind and branch outcome.
module rvbr_target_sel #(
    parameter int unsigned XLEN = 32
) (
    input  rvbr_pkg::xfer_kind_e kind_i,
    input  logic                 take_i,
    input  logic [XLEN-1:0]      pc_i,
    input  logic [XLEN-1:0]      base_i,
    input  logic [XLEN-1:0]      imm_b_i,
    input  logic [XLEN-1:0]      imm_j_i,
    input  logic [XLEN-1:0]      imm_i_i,
    output logic [XLEN-1:0]      seq_pc_o,
    output logic [XLEN-1:0]      next_pc_o,
    output logic                 redirect_o
);
    import rvbr_pkg::*;

    localparam logic [XLEN-1:0] STEP    = XLEN'(4);
    localparam logic [XLEN-1:0] LSB_CLR = ~XLEN'(1);

    logic [XLEN-1:0] rel_off;
    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] reg_tgt;

    // Computes the sequential, PC-relative and register-based addresses.
    always_comb begin
        seq_pc_o = pc_i + STEP;
        rel_off  = (kind_i == XFER_JAL) ? imm_j_i : imm_b_i;
        rel_tgt  = pc_i + rel_off;
        reg_tgt  = (base_i + imm_i_i) & LSB_CLR;
    end

    // Chooses the next fetch address.
    always_comb begin
        unique case (kind_i)
            XFER_JAL:    begin next_pc_o = rel_tgt;  redirect_o = 1'b1;   end
            XFER_JALR:   begin next_pc_o = reg_tgt;  redirect_o = 1'b1;   end
            XFER_BRANCH: begin
                next_pc_o  = take_i ? rel_tgt : seq_pc_o;
                redirect_o = take_i;
            end
            default:     begin next_pc_o = seq_pc_o; redirect_o = 1'b0;   end
        endcase
    end

endmodule

// File: rtl/rvbr_nextpc_unit.sv
// Module: top of the combinational control-transfer unit. Decodes the
// opcode, evaluates branches, selects the next PC and produces the link
// value. Assumes a 32-bit instruction word; no state, no reset.
module rvbr_nextpc_unit #(
    parameter int unsigned XLEN = 32
) (
    input  logic [31:0]      instr_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  src1_i,
    input  logic [XLEN-1:0]  src2_i,
    output logic [XLEN-1:0]  next_pc_o,
    output logic             redirect_o,
    output logic [XLEN-1:0]  link_val_o,
    output logic             link_we_o,
    output logic             br_illegal_o
);
    import rvbr_pkg::*;

    xfer_kind_e      kind;
    logic [4:0]      rd_idx;
    logic [XLEN-1:0] imm_b;
    logic [XLEN-1:0] imm_j;
    logic [XLEN-1:0] imm_i;
    logic            take;
    logic            bad_code;
    logic [XLEN-1:0] seq_pc;
    logic            is_jump;

    // Decodes the transfer kind and destination index.
    always_comb begin
        kind    = classify(instr_i[6:0]);
        rd_idx  = instr_i[11:7];
        is_jump = (kind == XFER_JAL) || (kind == XFER_JALR);
    end

    rvbr_imm_unpack #(.XLEN(XLEN)) u_imm (
        .ibits_i (instr_i[31:7]),
        .imm_b_o (imm_b),
        .imm_j_o (imm_j),
        .imm_i_o (imm_i)
    );

    rvbr_cond_eval #(.XLEN(XLEN)) u_cond (
        .lhs_i      (src1_i),
        .rhs_i      (src2_i),
        .code_i     (instr_i[14:12]),
        .take_o     (take),
        .bad_code_o (bad_code)
    );

    rvbr_target_sel #(.XLEN(XLEN)) u_tgt (
        .kind_i     (kind),
        .take_i     (take),
        .pc_i       (pc_i),
        .base_i     (src1_i),
        .imm_b_i    (imm_b),
        .imm_j_i    (imm_j),
        .imm_i_i    (imm_i),
        .seq_pc_o   (seq_pc),
        .next_pc_o  (next_pc_o),
        .redirect_o (redirect_o)
    );

    // Drives the link write-back and the reserved-code flag.
    always_comb begin
        link_val_o   = seq_pc;
        link_we_o    = is_jump && (rd_idx != 5'd0);
        br_illegal_o = (kind == XFER_BRANCH) && bad_code;
    end

    // Cross-checks between decode, condition and target logic.
    always_comb begin
        p_link_needs_redirect_r4: assert (!link_we_o || redirect_o)
            else $error("link write without redirect");
        p_fallthrough_seq_r1: assert (redirect_o || (next_pc_o == link_val_o))
            else $error("no redirect but next PC is not sequential");
        p_indirect_even_r3: assert (!(kind == XFER_JALR) || !next_pc_o[0])
            else $error("indirect target has bit 0 set");
        p_illegal_not_taken_r9: assert (!br_illegal_o || !redirect_o)
            else $error("reserved branch code redirected");
    end

endmodule

// File: tb/rvbr_nextpc_unit_test.sv
module rvbr_nextpc_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr, pc, a, b;
    logic [31:0] next_pc, link_val;
    logic        redirect, link_we, illegal;
    int          total = 0;
    int          bad = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    rvbr_nextpc_unit uut (
        .instr_i      (instr),
        .pc_i         (pc),
        .src1_i       (a),
        .src2_i       (b),
        .next_pc_o    (next_pc),
        .redirect_o   (redirect),
        .link_val_o   (link_val),
        .link_we_o    (link_we),
        .br_illegal_o (illegal)
    );

    function automatic logic [31:0] rnd(inout logic [31:0] s);
        s = s ^ (s << 13);
        s = s ^ (s >> 17);
        s = s ^ (s << 5);
        return s;
    endfunction

    function automatic logic [31:0] enc_branch(input logic [12:0] off, input logic [2:0] f3,
                                               input logic [4:0] r1, input logic [4:0] r2);
        return {off[12], off[10:5], r2, r1, f3, off[4:1], off[11], 7'b1100011};
    endfunction

    function automatic logic [31:0] enc_jal(input logic [20:0] off, input logic [4:0] rd);
        return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
    endfunction

    function automatic logic [31:0] enc_jalr(input logic [11:0] imm, input logic [4:0] r1,
                                             input logic [4:0] rd);
        return {imm, r1, 3'b000, rd, 7'b1100111};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h instr=%h pc=%h a=%h b=%h", req, got, exp, instr, pc, a, b);
        end
    endtask

    task automatic apply(input logic [31:0] i, input logic [31:0] p,
                         input logic [31:0] x, input logic [31:0] y);
        @(posedge clk);
        instr = i; pc = p; a = x; b = y;
        @(negedge clk);
    endtask

    task automatic check_all(input string req, input logic [31:0] e_next, input logic e_red,
                             input logic [31:0] e_link, input logic e_we, input logic e_ill);
        chk({req, " next_pc"}, next_pc, e_next);
        chk({req, " redirect"}, {31'd0, redirect}, {31'd0, e_red});
        chk({req, " link_val"}, link_val, e_link);
        chk({req, " link_we"}, {31'd0, link_we}, {31'd0, e_we});
        chk({req, " illegal"}, {31'd0, illegal}, {31'd0, e_ill});
    endtask

    logic [31:0] corners [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0005};
    logic [12:0] boffs [4] = '{13'h1000, 13'h0FFE, 13'h0002, 13'h1FFE};

    function automatic logic exp_take(input logic [2:0] f3, input logic [31:0] x, input logic [31:0] y);
        case (f3)
            3'b000: return x == y;
            3'b001: return x != y;
            3'b100: return $signed(x) < $signed(y);
            3'b101: return $signed(x) >= $signed(y);
            3'b110: return x < y;
            3'b111: return x >= y;
            default: return 1'b0;
        endcase
    endfunction

    initial begin : main
        instr = 32'h0; pc = 32'h0; a = 32'h0; b = 32'h0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiescent state with an all-zero word
        check_all("R1 reset", 32'h4, 1'b0, 32'h4, 1'b0, 1'b0);

        // R1: every non-control opcode falls through
        for (int op = 0; op < 128; op++) begin
            logic [31:0] r, p;
            if (op == 7'b1100011 || op == 7'b1101111 || op == 7'b1100111) continue;
            r = rnd(seed);
            p = rnd(seed) & ~32'h1;
            apply({r[31:7], 7'(op)}, p, rnd(seed), rnd(seed));
            check_all("R1 noncontrol", p + 32'd4, 1'b0, p + 32'd4, 1'b0, 1'b0);
        end

        // R5 R6 R7 R8 R9: all codes over corner operand pairs and edge offsets
        for (int f = 0; f < 8; f++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    for (int k = 0; k < 4; k++) begin
                        logic [31:0] p, tgt;
                        logic        t, il;
                        p   = rnd(seed) & ~32'h1;
                        t   = exp_take(3'(f), corners[i], corners[j]);
                        il  = (f == 2 || f == 3);
                        tgt = p + {{19{boffs[k][12]}}, boffs[k]};
                        apply(enc_branch(boffs[k], 3'(f), 5'(i + 1), 5'(j + 3)), p, corners[i], corners[j]);
                        if (il) check_all("R9 reserved", p + 32'd4, 1'b0, p + 32'd4, 1'b0, 1'b1);
                        else if (f < 2) check_all("R5 R8 eq/ne", t ? tgt : p + 32'd4, t, p + 32'd4, 1'b0, 1'b0);
                        else if (f < 6) check_all("R6 R8 signed", t ? tgt : p + 32'd4, t, p + 32'd4, 1'b0, 1'b0);
                        else check_all("R7 R8 unsigned", t ? tgt : p + 32'd4, t, p + 32'd4, 1'b0, 1'b0);
                    end
                end
            end
        end

        // R8: random branch offsets on a taken equality
        for (int n = 0; n < 100; n++) begin
            logic [31:0] p, v;
            logic [12:0] o;
            v = rnd(seed);
            o = {v[12:1], 1'b0};
            p = rnd(seed) & ~32'h1;
            apply(enc_branch(o, 3'b000, 5'd1, 5'd2), p, v, v);
            check_all("R8 offset", p + {{19{o[12]}}, o}, 1'b1, p + 32'd4, 1'b0, 1'b0);
        end

        // R2 R4: direct jumps, extreme and random offsets, all rd values
        for (int n = 0; n < 200; n++) begin
            logic [31:0] p, v;
            logic [20:0] o;
            logic [4:0]  rd;
            v  = rnd(seed);
            o  = (n == 0) ? 21'h100000 : (n == 1) ? 21'h0FFFFE : {v[20:1], 1'b0};
            rd = 5'(n);
            p  = rnd(seed) & ~32'h1;
            apply(enc_jal(o, rd), p, rnd(seed), rnd(seed));
            check_all("R2 R4 direct", p + {{11{o[20]}}, o}, 1'b1, p + 32'd4, rd != 5'd0, 1'b0);
        end

        // R3 R4: indirect jumps across the offset range
        for (int n = 0; n < 160; n++) begin
            logic [31:0] p, x;
            logic [11:0] im;
            logic [4:0]  rd;
            im = (n == 0) ? 12'h800 : (n == 1) ? 12'h7FF : 12'(n * 37 - 2048);
            x  = (n < 6) ? corners[n] : rnd(seed);
            rd = 5'(n + 7);
            p  = rnd(seed) & ~32'h1;
            apply(enc_jalr(im, 5'd9, rd), p, x, rnd(seed));
            check_all("R3 R4 indirect", (x + {{20{im[11]}}, im}) & ~32'h1, 1'b1, p + 32'd4, rd != 5'd0, 1'b0);
        end

        // R10: wraparound of sequential and relative sums
        apply(32'h0000_0013, 32'hFFFF_FFFC, 32'h0, 32'h0);
        check_all("R10 seq wrap", 32'h0, 1'b0, 32'h0, 1'b0, 1'b0);
        apply(enc_jal(21'h000020, 5'd1), 32'hFFFF_FFF0, 32'h0, 32'h0);
        check_all("R10 jump wrap", 32'h0000_0010, 1'b1, 32'hFFFF_FFF4, 1'b1, 1'b0);
        apply(enc_branch(13'h1FF0, 3'b001, 5'd1, 5'd2), 32'h0000_0008, 32'h1, 32'h2);
        check_all("R10 branch wrap", 32'hFFFF_FFF8, 1'b1, 32'h0000_000C, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule